// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns a fast internal clock into the SCL waveform of an I2C master and tells the byte sequencer exactly when to act on SDA. The host programs four cycle counts: the whole SCL period, the SCL low time, the setup delay for START and STOP edges, and the data setup lead. From these the block derives a drive strobe in the low phase, a sample strobe in the middle of the high phase, and a condition strobe in the high phase where a START (SDA falling) or STOP (SDA rising) edge is placed.

A two-bit control word gates the block. With the run bit low, both lines are released high, the counter rests, and the timing inputs are copied into internal registers. With the run bit high, those copies are frozen and the period runs. With run high and the release bit low, SCL is held low and no strobes are issued; raising the release bit restarts the period from its first cycle. The byte sequencer supplies the next data bit and START/STOP requests; the block registers SDA and the sampled receive bit. At a 50 MHz internal clock the counts suit bus rates up to 400 kHz.

Top module: `i2c_bit_timer`

## Requirements
- R1: While `run_en` is low, `scl_o` is high, no strobe is active, and `sda_o` is high from the first clock edge at which `run_en` is seen low; after reset both lines are high.
- R2: The effective period is P = max(`cfg_period`, 2) cycles and the low time is L = min(max(`cfg_low`, 1), P-1); counting cycles of a run from 0, `scl_o` is low in cycles 0..L-1 of each period and high in cycles L..P-1.
- R3: With D = max(`cfg_data_setup`, 1), `drive_tick` pulses once per period at cycle L-D, or at cycle 0 when D >= L; the cycle after it, `sda_o` equals `tx_bit` when no condition is requested.
- R4: `sample_tick` pulses once per period at cycle L + (P-L)/2 (integer division); the cycle after it, `rx_bit` equals the value `sda_i` had in the strobe cycle.
- R5: If `req_start` is high at the drive strobe, `sda_o` is driven high there; at cycle min(L + max(`cfg_cond_setup`,1), P-1) of the same period `start_tick` pulses and `sda_o` falls to low the cycle after.
- R6: If `req_stop` is high (and `req_start` low) at the drive strobe, `sda_o` is driven low there, and at the condition cycle of R5 `stop_tick` pulses and `sda_o` rises to high the cycle after; with both requests high, START wins.
- R7: While `run_en` is high and `scl_release` is low, `scl_o` is held low and no strobe is issued; when `scl_release` returns high the period restarts at cycle 0.
- R8: The timing inputs are captured only on clock edges at which `run_en` is low; changing them while running does not alter the timing until the next disable.
- R9: A zero in any timing input acts as the minimum value of R2, R3 and R5 (period 2, all other counts 1), so the period never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Normal operation enable |
| scl_release | input | 1 | Release of SCL low hold (1 = released) |
| cfg_period | input | CW | Cycles per SCL period |
| cfg_low | input | CW | Cycles SCL stays low per period |
| cfg_cond_setup | input | CW | Cycles from SCL rise to START/STOP edge |
| cfg_data_setup | input | CW | Cycles SDA leads the SCL rise |
| tx_bit | input | 1 | Next data bit to drive |
| req_start | input | 1 | Request a START in the current period |
| req_stop | input | 1 | Request a STOP in the current period |
| sda_i | input | 1 | Sensed SDA level |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| drive_tick | output | 1 | Strobe: SDA takes its next value |
| sample_tick | output | 1 | Strobe: SDA is sampled |
| start_tick | output | 1 | Strobe: START edge placed |
| stop_tick | output | 1 | Strobe: STOP edge placed |
| rx_bit | output | 1 | Last sampled SDA bit |

## Verification
The hardest situations to reach are those where strobe positions collide or clamp: a degenerate two-cycle period where the drive strobe falls on cycle 0 and sample, condition and SCL rise share one cycle, and a low count larger than the period. The stimulus reaches them by programming all-zero and oversized counts, then requests START and STOP in chosen periods so the collided strobes must still appear in the correct order. The held-low and frozen-configuration cases are reached by dropping the release bit mid-run and by rewriting the counts while running.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [1:0] {
    COND_NONE  = 2'd0,
    COND_START = 2'd1,
    COND_STOP  = 2'd2
  } cond_e;

endpackage

// File: rtl/i2c_bt_cfg.sv
module i2c_bt_cfg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] low_in,
  input  logic [CW-1:0] cond_su_in,
  input  logic [CW-1:0] data_su_in,
  output logic [CW-1:0] per_eff,
  output logic [CW-1:0] low_eff,
  output logic [CW-1:0] pos_drive,
  output logic [CW-1:0] pos_sample,
  output logic [CW-1:0] pos_cond
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] per_q, low_q, csu_q, dsu_q;
  logic [CW-1:0] per_d, low_d, csu_d, dsu_d;
  logic          cap_en;

  logic [CW-1:0] low_min, dsu_min, csu_min, per_last;
  logic [CW:0]   cond_sum;

  assign cap_en = ~run_en;

  always_comb begin
    per_d = per_q;
    low_d = low_q;
    csu_d = csu_q;
    dsu_d = dsu_q;
    if (cap_en) begin
      per_d = period_in;
      low_d = low_in;
      csu_d = cond_su_in;
      dsu_d = data_su_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      low_q <= '0;
      csu_q <= '0;
      dsu_q <= '0;
    end else begin
      per_q <= per_d;
      low_q <= low_d;
      csu_q <= csu_d;
      dsu_q <= dsu_d;
    end
  end

  always_comb begin
    per_eff    = (per_q < TWO) ? TWO : per_q;
    per_last   = per_eff - ONE;
    low_min    = (low_q == '0) ? ONE : low_q;
    low_eff    = (low_min > per_last) ? per_last : low_min;
    dsu_min    = (dsu_q == '0) ? ONE : dsu_q;
    pos_drive  = (dsu_min >= low_eff) ? '0 : (low_eff - dsu_min);
    pos_sample = low_eff + ((per_eff - low_eff) >> 1);
    csu_min    = (csu_q == '0) ? ONE : csu_q;
    cond_sum   = {1'b0, low_eff} + {1'b0, csu_min};
    pos_cond   = (cond_sum > {1'b0, per_last}) ? per_last : cond_sum[CW-1:0];
  end

endmodule

// File: rtl/i2c_bt_phase.sv
module i2c_bt_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          scl_release,
  input  logic [CW-1:0] per_eff,
  input  logic [CW-1:0] low_eff,
  input  logic [CW-1:0] pos_drive,
  input  logic [CW-1:0] pos_sample,
  input  logic [CW-1:0] pos_cond,
  output logic          scl_o,
  output logic          drv_tick,
  output logic          smp_tick,
  output logic          cond_tick
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          active;
  logic          wrap;

  assign active = run_en & scl_release;
  assign wrap   = (cnt_q == (per_eff - CW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    if (!run_en) begin
      scl_o = 1'b1;
    end else if (!scl_release) begin
      scl_o = 1'b0;
    end else begin
      scl_o = (cnt_q >= low_eff);
    end
  end

  assign drv_tick  = active & (cnt_q == pos_drive);
  assign smp_tick  = active & (cnt_q == pos_sample);
  assign cond_tick = active & (cnt_q == pos_cond);

endmodule

// File: rtl/i2c_bt_sda.sv
module i2c_bt_sda
  import i2c_bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic drv_tick,
  input  logic smp_tick,
  input  logic cond_tick,
  input  logic tx_bit,
  input  logic req_start,
  input  logic req_stop,
  input  logic sda_i,
  output logic sda_o,
  output logic rx_bit,
  output logic start_tick,
  output logic stop_tick
);

  cond_e pend_q, pend_d;
  logic  sda_q, sda_d;
  logic  rx_q, rx_d;

  always_comb begin
    pend_d = pend_q;
    sda_d  = sda_q;
    if (!run_en) begin
      pend_d = COND_NONE;
      sda_d  = 1'b1;
    end else if (drv_tick) begin
      if (req_start) begin
        pend_d = COND_START;
        sda_d  = 1'b1;
      end else if (req_stop) begin
        pend_d = COND_STOP;
        sda_d  = 1'b0;
      end else begin
        pend_d = COND_NONE;
        sda_d  = tx_bit;
      end
    end else if (cond_tick && (pend_q != COND_NONE)) begin
      sda_d  = (pend_q == COND_STOP);
      pend_d = COND_NONE;
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (smp_tick) begin
      rx_d = sda_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= COND_NONE;
      sda_q  <= 1'b1;
      rx_q   <= 1'b1;
    end else begin
      pend_q <= pend_d;
      sda_q  <= sda_d;
      rx_q   <= rx_d;
    end
  end

  assign sda_o      = sda_q;
  assign rx_bit     = rx_q;
  assign start_tick = cond_tick & (pend_q == COND_START);
  assign stop_tick  = cond_tick & (pend_q == COND_STOP);

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          scl_release,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_cond_setup,
  input  logic [CW-1:0] cfg_data_setup,
  input  logic          tx_bit,
  input  logic          req_start,
  input  logic          req_stop,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_o,
  output logic          drive_tick,
  output logic          sample_tick,
  output logic          start_tick,
  output logic          stop_tick,
  output logic          rx_bit
);

  logic [CW-1:0] per_eff, low_eff, pos_drive, pos_sample, pos_cond;
  logic          drv_tick, smp_tick, cond_tick;

  i2c_bt_cfg #(.CW(CW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .period_in  (cfg_period),
    .low_in     (cfg_low),
    .cond_su_in (cfg_cond_setup),
    .data_su_in (cfg_data_setup),
    .per_eff    (per_eff),
    .low_eff    (low_eff),
    .pos_drive  (pos_drive),
    .pos_sample (pos_sample),
    .pos_cond   (pos_cond)
  );

  i2c_bt_phase #(.CW(CW)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .scl_release (scl_release),
    .per_eff     (per_eff),
    .low_eff     (low_eff),
    .pos_drive   (pos_drive),
    .pos_sample  (pos_sample),
    .pos_cond    (pos_cond),
    .scl_o       (scl_o),
    .drv_tick    (drv_tick),
    .smp_tick    (smp_tick),
    .cond_tick   (cond_tick)
  );

  i2c_bt_sda u_sda (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .drv_tick   (drv_tick),
    .smp_tick   (smp_tick),
    .cond_tick  (cond_tick),
    .tx_bit     (tx_bit),
    .req_start  (req_start),
    .req_stop   (req_stop),
    .sda_i      (sda_i),
    .sda_o      (sda_o),
    .rx_bit     (rx_bit),
    .start_tick (start_tick),
    .stop_tick  (stop_tick)
  );

  assign drive_tick  = drv_tick;
  assign sample_tick = smp_tick;

endmodule

// File: rtl/i2c_bt_chk.sv
module i2c_bt_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic scl_release,
  input logic sda_i,
  input logic scl_o,
  input logic sda_o,
  input logic drive_tick,
  input logic sample_tick,
  input logic start_tick,
  input logic stop_tick,
  input logic rx_bit
);

  // R1
  idle_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (scl_o && !drive_tick && !sample_tick && !start_tick && !stop_tick));

  // R1
  idle_sda_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> sda_o);

  // R7
  held_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !scl_release) |-> (!scl_o && !drive_tick && !sample_tick && !start_tick && !stop_tick));

  // R3
  drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_tick |-> !scl_o);

  // R4
  sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> scl_o);

  // R4
  sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> (rx_bit == $past(sda_i)));

  // R5
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_tick |-> (scl_o && sda_o) ##1 !sda_o);

  // R6
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_tick |-> (scl_o && !sda_o) ##1 sda_o);

  // R6
  one_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_tick, stop_tick}));

endmodule

bind i2c_bit_timer i2c_bt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .scl_release (scl_release),
  .sda_i       (sda_i),
  .scl_o       (scl_o),
  .sda_o       (sda_o),
  .drive_tick  (drive_tick),
  .sample_tick (sample_tick),
  .start_tick  (start_tick),
  .stop_tick   (stop_tick),
  .rx_bit      (rx_bit)
);

// File: tb/tb_i2c_bit_timer.sv
`timescale 1ns/1ps
module tb_i2c_bit_timer;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run_en, scl_release;
  logic [CW-1:0] cfg_period, cfg_low, cfg_cond_setup, cfg_data_setup;
  logic          tx_bit, req_start, req_stop, sda_i;
  logic          scl_o, sda_o, drive_tick, sample_tick, start_tick, stop_tick, rx_bit;

  always #2.5 clk = ~clk;

  i2c_bit_timer #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .scl_release(scl_release),
    .cfg_period(cfg_period), .cfg_low(cfg_low),
    .cfg_cond_setup(cfg_cond_setup), .cfg_data_setup(cfg_data_setup),
    .tx_bit(tx_bit), .req_start(req_start), .req_stop(req_stop), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .drive_tick(drive_tick),
    .sample_tick(sample_tick), .start_tick(start_tick), .stop_tick(stop_tick),
    .rx_bit(rx_bit)
  );

  // event kinds: 0 drive, 1 SCL rise, 2 sample, 3 start, 4 stop
  typedef struct {
    int    kind;
    int    cyc;
    bit    val;
    string req;
  } ev_t;

  ev_t   expq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    eP, eL, ePd, ePs, ePc;
  int    pbase;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected positions straight from R2, R3, R4, R5, R9
  task automatic set_expect(input int per, input int low, input int csu, input int dsu);
    int d, s;
    eP  = (per < 2) ? 2 : per;
    eL  = (low < 1) ? 1 : low;
    if (eL > eP - 1) eL = eP - 1;
    d   = (dsu < 1) ? 1 : dsu;
    ePd = (d >= eL) ? 0 : eL - d;
    ePs = eL + (eP - eL) / 2;
    s   = (csu < 1) ? 1 : csu;
    ePc = (eL + s > eP - 1) ? eP - 1 : eL + s;
  endtask

  task automatic push(input int kind, input int cyc, input bit val, input string req);
    ev_t e;
    e.kind = kind; e.cyc = cyc; e.val = val; e.req = req;
    expq.push_back(e);
  endtask

  task automatic enable(input int per, input int low, input int csu, input int dsu);
    run_en = 1'b0;
    cfg_period = CW'(per); cfg_low = CW'(low);
    cfg_cond_setup = CW'(csu); cfg_data_setup = CW'(dsu);
    @(posedge clk); #1;
    run_en = 1'b1;
    set_expect(per, low, csu, dsu);
    pbase = 0;
  endtask

  // driver: pushes expected events of n periods, then lets them elapse
  task automatic run_periods(input int n, input logic [7:0] bits,
                             input int start_at, input int stop_at);
    for (int k = 0; k < n; k++) begin
      int  b;
      bit  cs, cp, dv;
      b  = (pbase + k) * eP;
      cs = (k == start_at);
      cp = (k == stop_at);
      tx_bit    = bits[k % 8];
      sda_i     = ~bits[k % 8];
      req_start = cs;
      req_stop  = cp;
      dv = cs ? 1'b1 : (cp ? 1'b0 : bits[k % 8]);
      push(0, b + ePd, dv, cs ? "R5" : (cp ? "R6" : "R3"));
      push(1, b + eL, 1'b0, "R2");
      if (ePs <= ePc) push(2, b + ePs, ~bits[k % 8], "R4");
      if (cs)         push(3, b + ePc, 1'b0, "R5");
      else if (cp)    push(4, b + ePc, 1'b1, "R6");
      if (ePs > ePc)  push(2, b + ePs, ~bits[k % 8], "R4");
      repeat (eP) @(posedge clk);
      #1;
    end
    pbase += n;
    req_start = 1'b0;
    req_stop  = 1'b0;
  endtask

  // monitor
  int  mcyc = 0;
  bit  scl_prev = 1'b1;
  bit  post_sda_v = 0, post_sda = 0, post_rx_v = 0, post_rx = 0;
  string post_sda_req, post_rx_req;

  task automatic observe(input int kind);
    ev_t e;
    if (expq.size() == 0) begin
      check(1'b0, "R2 unexpected strobe", kind, -1);
      return;
    end
    e = expq.pop_front();
    check(e.kind == kind, e.req, kind, e.kind);
    check(e.cyc == mcyc, e.req, mcyc, e.cyc);
    if (kind == 0 || kind == 3 || kind == 4) begin
      post_sda_v = 1; post_sda = e.val; post_sda_req = e.req;
    end else if (kind == 2) begin
      post_rx_v = 1; post_rx = e.val; post_rx_req = e.req;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (post_sda_v) begin
        check(sda_o == post_sda, post_sda_req, sda_o, post_sda);
        post_sda_v = 0;
      end
      if (post_rx_v) begin
        check(rx_bit == post_rx, post_rx_req, rx_bit, post_rx);
        post_rx_v = 0;
      end
      if (run_en && scl_release) begin
        if (drive_tick)            observe(0);
        if (scl_o && !scl_prev)    observe(1);
        if (sample_tick)           observe(2);
        if (start_tick)            observe(3);
        if (stop_tick)             observe(4);
        mcyc++;
      end else begin
        if (drive_tick || sample_tick || start_tick || stop_tick)
          check(1'b0, "R7 strobe while not running", 1, 0);
        mcyc = 0;
      end
      scl_prev = scl_o;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; scl_release = 1'b1;
    cfg_period = '0; cfg_low = '0; cfg_cond_setup = '0; cfg_data_setup = '0;
    tx_bit = 1'b0; req_start = 1'b0; req_stop = 1'b0; sda_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(scl_o == 1'b1, "R1 reset scl", scl_o, 1);
    check(sda_o == 1'b1, "R1 reset sda", sda_o, 1);
    check(!(drive_tick | sample_tick | start_tick | stop_tick), "R1 reset strobes", 1, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R2 R3 R4 basic timing, then START and STOP (R5 R6)
    enable(10, 5, 5, 1);
    run_periods(4, 8'b1011_0010, -1, -1);
    run_periods(3, 8'b0101_1100, 0, 2);

    // R1 disabled with non-zero timing programmed
    run_en = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(scl_o == 1'b1, "R1 disabled scl", scl_o, 1);
      check(sda_o == 1'b1, "R1 disabled sda", sda_o, 1);
    end
    @(posedge clk); #1;

    // R9 all-zero counts: period 2, strobes collide
    enable(0, 0, 0, 0);
    run_periods(6, 8'b0110_1001, 1, 4);

    // R2 low count beyond the period is clamped
    enable(6, 9, 1, 2);
    run_periods(3, 8'b1100_0110, 2, -1);

    // R6 both requests: START wins; condition before sample
    enable(20, 8, 3, 3);
    run_periods(3, 8'b1001_0011, 1, 1);
    run_periods(1, 8'b0000_0001, -1, 0);

    // R7 SCL held low, then restart from cycle 0
    scl_release = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(scl_o == 1'b0, "R7 held low", scl_o, 0);
    end
    @(posedge clk); #1;
    scl_release = 1'b1;
    pbase = 0;
    run_periods(2, 8'b1110_0101, -1, -1);

    // R8 rewrite while running has no effect until disable
    enable(10, 5, 5, 1);
    cfg_period = CW'(20); cfg_low = CW'(8);
    cfg_cond_setup = CW'(3); cfg_data_setup = CW'(3);
    run_periods(2, 8'b0011_1010, 1, -1);
    enable(20, 8, 3, 3);
    run_periods(2, 8'b1010_1100, -1, 1);

    run_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R2 missing strobes", expq.size(), 0);
    finish_run();
  end

endmodule